// File: doc/BRIEF.md
# SPI Word / FIFO Word Packer

This block adapts the fixed 32-bit data path of a transmit and receive FIFO to the variable-length word stream of an SPI shift engine. On the transmit side it takes one FIFO word at a time and hands out the SPI words it contains. Words leave one per accepted handshake, lowest lane first. On the receive side it gathers incoming SPI words into FIFO words and pushes each word to the FIFO as soon as it is full. When the engine marks the final word of a transfer, it pushes the partly filled word as well, together with a last flag and the number of valid bytes in it.

The SPI word length can be any value from 4 to 32 bits. When it divides 32 evenly, several SPI words share one FIFO word, and word i sits at bit offset i times the word length. When it does not, each FIFO word carries exactly one SPI word at bit 0. That word occupies the smallest power-of-two number of bytes that holds it. A command-start pulse latches the word length and clears any half-used transmit word and any partial receive word, so the packing cannot change during a transfer. The FIFO storage and the serial shifter sit outside the block.

Top module: `spi_word_packer`

## Requirements
- R1: When 32 is an exact multiple of the latched word length L (L = 4, 8, 16 or 32), each popped FIFO word produces 32/L SPI words on `tx_word_data`, right-aligned, taken from bit offsets 0, L, 2L and so on in that order.
- R2: When L does not divide 32, each popped FIFO word produces exactly one SPI word, equal to its low L bits. Bits at L and above are ignored.
- R3: While `tx_word_valid` is high and `tx_word_ready` is low, the offered word stays unchanged and stays valid until it is accepted. Backpressure loses and repeats no word.
- R4: On receive, incoming SPI words are masked to L bits and placed into lanes of increasing bit offset (i times L for an exact multiple, otherwise offset 0 only). A FIFO word is pushed one cycle after the word that fills it.
- R5: An incoming word with `rx_word_last` set forces a push one cycle later, even if the FIFO word is only partly filled, with `rx_fifo_last` = 1. For an exact multiple, `rx_fifo_bytes` = ceil(k*L/8) for k packed words. On pushes without the last flag, `rx_fifo_bytes` is 0.
- R6: When L does not divide 32, the final push reports `rx_fifo_bytes` as ceil(L/8) rounded up to a power of two: 1 for L = 5..7, 2 for L = 9..15, and 4 for L = 17..31.
- R7: The word length is latched only in the cycle `cmd_start` is high. Changes on `cfg_word_len` at any other time have no effect on packing.
- R8: `cmd_start` discards the unused lanes of a partly consumed transmit FIFO word and any partial receive accumulation. While `cmd_start` is high, `tx_word_valid` and `tx_fifo_ready` are low and receive input is ignored.
- R9: A requested word length below 4 is latched as 4, and one above 32 is latched as 32.
- R10: `rx_push_count` counts FIFO pushes since the last `cmd_start`. It steps in the same cycle that `rx_fifo_valid` is high and clears in the cycle after `cmd_start`.
- R11: After reset, no word is offered or pushed, the count is 0, `tx_fifo_ready` is high, and the word length is 8.
- R12: A new FIFO word is popped in the same cycle that the last lane of the current one is accepted. With the sink always ready, 32-bit words stream one per cycle with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start of a command: latches the word length and clears partial state |
| cfg_word_len | input | 6 | Requested SPI word length in bits |
| tx_fifo_valid | input | 1 | Transmit FIFO has a word |
| tx_fifo_data | input | 32 | Transmit FIFO head word |
| tx_fifo_ready | output | 1 | Pop strobe toward the transmit FIFO |
| tx_word_valid | output | 1 | An SPI word is offered to the shifter |
| tx_word_data | output | 32 | Offered SPI word, right-aligned |
| tx_word_ready | input | 1 | Shifter accepts the offered word |
| rx_word_valid | input | 1 | Shifter delivers a received SPI word |
| rx_word_data | input | 32 | Received SPI word, right-aligned |
| rx_word_last | input | 1 | Received word is the final one of the transfer |
| rx_fifo_valid | output | 1 | Push strobe toward the receive FIFO |
| rx_fifo_data | output | 32 | Packed receive FIFO word |
| rx_fifo_last | output | 1 | Pushed word ends the transfer |
| rx_fifo_bytes | output | 3 | Valid bytes of the final word (1 to 4), 0 otherwise |
| rx_push_count | output | 16 | Receive FIFO words pushed since command start |

## Verification
The bench builds the block with its defaults, a 32-bit FIFO word and a 16-bit push counter. It then reaches every packing class by changing only the latched word length: 4, 8, 16 and 32 for exact packing, and 6, 12 and 20 for one-, two- and four-byte slots. It also starts commands at 2 and 40 to reach the clamp limits. Partial final receive words are exercised at several fill levels. A command is restarted with a transmit word half consumed and a receive word half gathered. Alternating sink readiness exposes the hold behaviour, and an always-ready 32-bit stream measures the gap-free pop.

// File: rtl/spk_pkg.sv
package spk_pkg;

    localparam int SPK_FIFO_W = 32;
    localparam int SPK_MIN_WL = 4;
    localparam int SPK_LEN_W  = $clog2(SPK_FIFO_W) + 1;
    localparam int SPK_CNT_W  = $clog2(SPK_FIFO_W / SPK_MIN_WL) + 1;
    localparam int SPK_BYTES  = SPK_FIFO_W / 8;
    localparam int SPK_BCNT_W = $clog2(SPK_BYTES) + 1;

    typedef logic [SPK_FIFO_W-1:0] fword_t;

    typedef struct packed {
        logic [SPK_LEN_W-1:0]  wlen;
        logic [SPK_CNT_W-1:0]  wpf;
        logic [SPK_BCNT_W-1:0] slot_bytes;
        logic                  exact;
        fword_t                mask;
    } pack_cfg_t;

    function automatic pack_cfg_t build_cfg(input logic [SPK_LEN_W-1:0] req);
        pack_cfg_t c;
        int wl;
        int nb;
        int p;
        wl = int'(req);
        if (wl < SPK_MIN_WL) wl = SPK_MIN_WL;
        if (wl > SPK_FIFO_W) wl = SPK_FIFO_W;
        c.wlen  = SPK_LEN_W'(wl);
        c.exact = ((SPK_FIFO_W % wl) == 0);
        c.wpf   = c.exact ? SPK_CNT_W'(SPK_FIFO_W / wl) : SPK_CNT_W'(1);
        nb = (wl + 7) / 8;
        p  = 1;
        for (int i = 0; i < SPK_BCNT_W; i++) begin
            if (p < nb) p = p * 2;
        end
        c.slot_bytes = SPK_BCNT_W'(p);
        c.mask = {SPK_FIFO_W{1'b1}} >> (SPK_FIFO_W - wl);
        return c;
    endfunction

    function automatic int lane_offset(input logic [SPK_CNT_W-1:0] lane, input pack_cfg_t c);
        return int'(lane) * int'(c.wlen);
    endfunction

    function automatic fword_t lane_extract(input fword_t w, input logic [SPK_CNT_W-1:0] lane,
                                            input pack_cfg_t c);
        return (w >> lane_offset(lane, c)) & c.mask;
    endfunction

    function automatic fword_t lane_insert(input fword_t d, input logic [SPK_CNT_W-1:0] lane,
                                           input pack_cfg_t c);
        return (d & c.mask) << lane_offset(lane, c);
    endfunction

    function automatic logic [SPK_BCNT_W-1:0] tail_bytes(input pack_cfg_t c,
                                                         input logic [SPK_CNT_W-1:0] filled);
        int bits;
        if (!c.exact) return c.slot_bytes;
        bits = int'(filled) * int'(c.wlen);
        return SPK_BCNT_W'((bits + 7) / 8);
    endfunction

endpackage

// File: rtl/spk_cfg_latch.sv
module spk_cfg_latch
    import spk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_start,
    input  logic [SPK_LEN_W-1:0] req_len,
    output pack_cfg_t            cfg
);

    localparam logic [SPK_LEN_W-1:0] RESET_LEN = SPK_LEN_W'(8);

    pack_cfg_t cfg_q;
    pack_cfg_t cfg_nx;

    always_comb begin
        cfg_nx = build_cfg(req_len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= build_cfg(RESET_LEN);
        end else if (cmd_start) begin
            cfg_q <= cfg_nx;
        end
    end

    assign cfg = cfg_q;

    // Latched length always inside the legal window
    assert_wlen_range_R9: assert property (@(posedge clk) disable iff (rst)
        (int'(cfg_q.wlen) >= SPK_MIN_WL) && (int'(cfg_q.wlen) <= SPK_FIFO_W));

    // Packing configuration only moves on a command start
    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !cmd_start |=> $stable(cfg_q));

endmodule

// File: rtl/spk_tx_unpack.sv
module spk_tx_unpack
    import spk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_start,
    input  pack_cfg_t cfg,
    input  logic      tx_fifo_valid,
    input  fword_t    tx_fifo_data,
    output logic      tx_fifo_ready,
    output logic      tx_word_valid,
    output fword_t    tx_word_data,
    input  logic      tx_word_ready
);

    fword_t               hold_q;
    logic                 full_q;
    logic [SPK_CNT_W-1:0] lane_q;
    logic                 last_lane;
    logic                 take;
    logic                 pop;

    always_comb begin
        last_lane     = (lane_q == (cfg.wpf - SPK_CNT_W'(1)));
        tx_word_valid = full_q & ~cmd_start;
        take          = tx_word_valid & tx_word_ready;
        tx_fifo_ready = ~cmd_start & (~full_q | (take & last_lane));
        pop           = tx_fifo_valid & tx_fifo_ready;
        tx_word_data  = lane_extract(hold_q, lane_q, cfg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            full_q <= 1'b0;
            lane_q <= '0;
        end else if (cmd_start) begin
            full_q <= 1'b0;
            lane_q <= '0;
        end else if (pop) begin
            hold_q <= tx_fifo_data;
            full_q <= 1'b1;
            lane_q <= '0;
        end else if (take) begin
            if (last_lane) begin
                full_q <= 1'b0;
                lane_q <= '0;
            end else begin
                lane_q <= lane_q + SPK_CNT_W'(1);
            end
        end
    end

    // A stalled word is held unchanged until taken or a new command starts
    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_word_valid && !tx_word_ready) |=>
            (cmd_start || (tx_word_valid && $stable(tx_word_data))));

    // A pop is followed by an offered word in the next cycle
    assert_pop_offers_R12: assert property (@(posedge clk) disable iff (rst)
        (tx_fifo_valid && tx_fifo_ready) |=> (tx_word_valid || cmd_start));

    // Nothing moves on the transmit side during a command start
    assert_start_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> (!tx_word_valid && !(tx_fifo_valid && tx_fifo_ready)));

    // Lane index never reaches the packing factor
    assert_lane_bound_R1: assert property (@(posedge clk) disable iff (rst)
        full_q |-> (lane_q < cfg.wpf));

endmodule

// File: rtl/spk_rx_pack.sv
module spk_rx_pack
    import spk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_start,
    input  pack_cfg_t             cfg,
    input  logic                  rx_word_valid,
    input  fword_t                rx_word_data,
    input  logic                  rx_word_last,
    output logic                  rx_fifo_valid,
    output fword_t                rx_fifo_data,
    output logic                  rx_fifo_last,
    output logic [SPK_BCNT_W-1:0] rx_fifo_bytes,
    output logic [CNT_W-1:0]      rx_push_count
);

    fword_t                acc_q;
    logic [SPK_CNT_W-1:0]  fill_q;
    fword_t                acc_nx;
    logic [SPK_CNT_W-1:0]  fill_nx;
    logic                  accept;
    logic                  flush;
    logic [SPK_BCNT_W-1:0] tail_nx;

    always_comb begin
        accept  = rx_word_valid & ~cmd_start;
        acc_nx  = acc_q | lane_insert(rx_word_data, fill_q, cfg);
        fill_nx = fill_q + SPK_CNT_W'(1);
        flush   = accept & ((fill_nx == cfg.wpf) | rx_word_last);
        tail_nx = tail_bytes(cfg, fill_nx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q         <= '0;
            fill_q        <= '0;
            rx_fifo_valid <= 1'b0;
            rx_fifo_data  <= '0;
            rx_fifo_last  <= 1'b0;
            rx_fifo_bytes <= '0;
            rx_push_count <= '0;
        end else begin
            rx_fifo_valid <= flush;
            if (cmd_start) begin
                acc_q         <= '0;
                fill_q        <= '0;
                rx_push_count <= '0;
            end else if (accept) begin
                if (flush) begin
                    acc_q         <= '0;
                    fill_q        <= '0;
                    rx_fifo_data  <= acc_nx;
                    rx_fifo_last  <= rx_word_last;
                    rx_fifo_bytes <= rx_word_last ? tail_nx : '0;
                    rx_push_count <= rx_push_count + CNT_W'(1);
                end else begin
                    acc_q  <= acc_nx;
                    fill_q <= fill_nx;
                end
            end
        end
    end

    // A final input word always yields a final push one cycle later
    assert_last_push_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_word_valid && rx_word_last && !cmd_start) |=> (rx_fifo_valid && rx_fifo_last));

    // Byte count only on a final push
    assert_bytes_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_fifo_valid && !rx_fifo_last) |-> (rx_fifo_bytes == '0));

    // Final push reports between one and a full word of bytes
    assert_bytes_range_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_fifo_valid && rx_fifo_last) |->
            ((rx_fifo_bytes != '0) && (int'(rx_fifo_bytes) <= SPK_BYTES)));

    // Counter steps together with every push
    assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_fifo_valid && !$past(cmd_start)) |-> (rx_push_count == $past(rx_push_count) + CNT_W'(1)));

    // Ignored input during a command start produces no push
    assert_start_no_push_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> !rx_fifo_valid);

endmodule

// File: rtl/spi_word_packer.sv
module spi_word_packer
    import spk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_start,
    input  logic [SPK_LEN_W-1:0]  cfg_word_len,
    input  logic                  tx_fifo_valid,
    input  logic [SPK_FIFO_W-1:0] tx_fifo_data,
    output logic                  tx_fifo_ready,
    output logic                  tx_word_valid,
    output logic [SPK_FIFO_W-1:0] tx_word_data,
    input  logic                  tx_word_ready,
    input  logic                  rx_word_valid,
    input  logic [SPK_FIFO_W-1:0] rx_word_data,
    input  logic                  rx_word_last,
    output logic                  rx_fifo_valid,
    output logic [SPK_FIFO_W-1:0] rx_fifo_data,
    output logic                  rx_fifo_last,
    output logic [SPK_BCNT_W-1:0] rx_fifo_bytes,
    output logic [CNT_W-1:0]      rx_push_count
);

    pack_cfg_t cfg;

    spk_cfg_latch u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cmd_start (cmd_start),
        .req_len   (cfg_word_len),
        .cfg       (cfg)
    );

    spk_tx_unpack u_tx (
        .clk           (clk),
        .rst           (rst),
        .cmd_start     (cmd_start),
        .cfg           (cfg),
        .tx_fifo_valid (tx_fifo_valid),
        .tx_fifo_data  (tx_fifo_data),
        .tx_fifo_ready (tx_fifo_ready),
        .tx_word_valid (tx_word_valid),
        .tx_word_data  (tx_word_data),
        .tx_word_ready (tx_word_ready)
    );

    spk_rx_pack #(
        .CNT_W (CNT_W)
    ) u_rx (
        .clk           (clk),
        .rst           (rst),
        .cmd_start     (cmd_start),
        .cfg           (cfg),
        .rx_word_valid (rx_word_valid),
        .rx_word_data  (rx_word_data),
        .rx_word_last  (rx_word_last),
        .rx_fifo_valid (rx_fifo_valid),
        .rx_fifo_data  (rx_fifo_data),
        .rx_fifo_last  (rx_fifo_last),
        .rx_fifo_bytes (rx_fifo_bytes),
        .rx_push_count (rx_push_count)
    );

endmodule

// File: tb/spi_word_packer_tb.sv
module spi_word_packer_tb;
    import spk_pkg::*;

    localparam int CNT_W = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                  rst;
    logic                  cmd_start;
    logic [SPK_LEN_W-1:0]  cfg_word_len;
    logic                  tx_fifo_valid;
    logic [31:0]           tx_fifo_data;
    logic                  tx_fifo_ready;
    logic                  tx_word_valid;
    logic [31:0]           tx_word_data;
    logic                  tx_word_ready;
    logic                  rx_word_valid;
    logic [31:0]           rx_word_data;
    logic                  rx_word_last;
    logic                  rx_fifo_valid;
    logic [31:0]           rx_fifo_data;
    logic                  rx_fifo_last;
    logic [SPK_BCNT_W-1:0] rx_fifo_bytes;
    logic [CNT_W-1:0]      rx_push_count;

    spi_word_packer #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cfg_word_len(cfg_word_len),
        .tx_fifo_valid(tx_fifo_valid), .tx_fifo_data(tx_fifo_data), .tx_fifo_ready(tx_fifo_ready),
        .tx_word_valid(tx_word_valid), .tx_word_data(tx_word_data), .tx_word_ready(tx_word_ready),
        .rx_word_valid(rx_word_valid), .rx_word_data(rx_word_data), .rx_word_last(rx_word_last),
        .rx_fifo_valid(rx_fifo_valid), .rx_fifo_data(rx_fifo_data), .rx_fifo_last(rx_fifo_last),
        .rx_fifo_bytes(rx_fifo_bytes), .rx_push_count(rx_push_count)
    );

    typedef struct {
        logic [31:0] d;
        bit          last;
    } rxin_t;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    string cur_tag = "R11";

    logic [31:0] txq[$];
    rxin_t       rxq[$];
    logic [31:0] exp_tx[$];

    bit start_req = 0;
    int ready_mode = 0;
    int budget = -1;
    int ncyc = 0;
    int hs_first = -1;
    int hs_last = -1;
    int hs_n = 0;

    // reference model state
    int          m_wl, m_wpf, m_slot;
    bit          m_exact;
    logic [31:0] m_mask, m_acc;
    int          m_k;
    bit          exp_rv;
    logic [31:0] exp_rd;
    bit          exp_rl;
    int          exp_rb;
    int          exp_cnt;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic void set_model_cfg(input int req);
        int wl;
        wl = req;
        if (wl < 4) wl = 4;
        if (wl > 32) wl = 32;
        m_wl    = wl;
        m_exact = (wl == 4) || (wl == 8) || (wl == 16) || (wl == 32);
        m_wpf   = m_exact ? 32 / wl : 1;
        m_slot  = (wl <= 8) ? 1 : ((wl <= 16) ? 2 : 4);
        m_mask  = (wl == 32) ? 32'hFFFF_FFFF : ((32'h1 << wl) - 32'h1);
    endfunction

    // driver and per-cycle comparison
    initial begin
        set_model_cfg(8);
        m_acc = 0; m_k = 0; exp_rv = 0; exp_rd = 0; exp_rl = 0; exp_rb = 0; exp_cnt = 0;
        forever begin
            @(negedge clk);
            tx_fifo_valid = (txq.size() > 0);
            tx_fifo_data  = (txq.size() > 0) ? txq[0] : 32'h0;
            rx_word_valid = (rxq.size() > 0);
            rx_word_data  = (rxq.size() > 0) ? rxq[0].d : 32'h0;
            rx_word_last  = (rxq.size() > 0) ? rxq[0].last : 1'b0;
            cmd_start     = start_req;
            tx_word_ready = (budget != 0) && ((ready_mode == 0) || (ncyc % 2 == 1));
            #1;
            if (!rst) begin
                ncyc++;
                chk(rx_fifo_valid == exp_rv, cur_tag, "rx push strobe", 32'(rx_fifo_valid), 32'(exp_rv));
                if (exp_rv) begin
                    chk(rx_fifo_data == exp_rd, cur_tag, "rx packed data", rx_fifo_data, exp_rd);
                    chk(rx_fifo_last == exp_rl, cur_tag, "rx last flag", 32'(rx_fifo_last), 32'(exp_rl));
                    chk(int'(rx_fifo_bytes) == exp_rb, cur_tag, "rx valid bytes", 32'(rx_fifo_bytes), 32'(exp_rb));
                end
                chk(int'(rx_push_count) == exp_cnt, "R10", "push count", 32'(rx_push_count), 32'(exp_cnt));
                if (cmd_start)
                    chk(!tx_word_valid && !tx_fifo_ready, "R8", "quiet on start",
                        {30'h0, tx_word_valid, tx_fifo_ready}, 32'h0);
                if (tx_word_valid && tx_word_ready) begin
                    if (exp_tx.size() == 0) begin
                        chk(1'b0, cur_tag, "unexpected tx word", tx_word_data, 32'h0);
                    end else begin
                        chk(tx_word_data == exp_tx[0], cur_tag, "tx word", tx_word_data, exp_tx[0]);
                        void'(exp_tx.pop_front());
                    end
                    if (hs_first < 0) hs_first = ncyc;
                    hs_last = ncyc;
                    hs_n++;
                    if (budget > 0) budget--;
                end
                if (tx_fifo_valid && tx_fifo_ready) begin
                    logic [31:0] w;
                    w = txq.pop_front();
                    for (int i = 0; i < m_wpf; i++) exp_tx.push_back((w >> (i * m_wl)) & m_mask);
                end
                exp_rv = 0;
                if (cmd_start) begin
                    set_model_cfg(int'(cfg_word_len));
                    exp_tx.delete();
                    m_acc = 0; m_k = 0; exp_cnt = 0;
                    start_req = 0;
                    if (rx_word_valid) void'(rxq.pop_front());
                end else if (rx_word_valid) begin
                    rxin_t it;
                    it = rxq.pop_front();
                    m_acc = m_acc | ((it.d & m_mask) << (m_k * m_wl));
                    m_k++;
                    if (m_k == m_wpf || it.last) begin
                        exp_rv = 1;
                        exp_rd = m_acc;
                        exp_rl = it.last;
                        exp_rb = it.last ? (m_exact ? (m_k * m_wl + 7) / 8 : m_slot) : 0;
                        exp_cnt++;
                        m_acc = 0; m_k = 0;
                    end
                end
            end
        end
    end

    task automatic do_start(input int len);
        @(negedge clk);
        cfg_word_len = SPK_LEN_W'(len);
        start_req = 1;
        while (start_req) @(negedge clk);
    endtask

    task automatic push_tx(input int n);
        for (int i = 0; i < n; i++) txq.push_back($urandom());
    endtask

    task automatic push_rx(input int n, input bit last_at_end);
        for (int i = 0; i < n; i++) begin
            rxin_t it;
            it.d = $urandom();
            it.last = last_at_end && (i == n - 1);
            rxq.push_back(it);
        end
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        while ((txq.size() > 0 || rxq.size() > 0 || exp_tx.size() > 0 || exp_rv || tx_word_valid) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
        chk(t < 3000, cur_tag, "drain timeout", 32'(t), 32'd3000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_err++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst = 1;
        cmd_start = 0; cfg_word_len = SPK_LEN_W'(8);
        tx_fifo_valid = 0; tx_fifo_data = 0; tx_word_ready = 0;
        rx_word_valid = 0; rx_word_data = 0; rx_word_last = 0;
        repeat (4) @(negedge clk);
        #1;
        // R11 reset state
        chk(!tx_word_valid, "R11", "tx valid after reset", 32'(tx_word_valid), 32'h0);
        chk(!rx_fifo_valid, "R11", "rx push after reset", 32'(rx_fifo_valid), 32'h0);
        chk(rx_push_count == 0, "R11", "count after reset", 32'(rx_push_count), 32'h0);
        chk(tx_fifo_ready, "R11", "fifo ready after reset", 32'(tx_fifo_ready), 32'h1);
        @(negedge clk);
        rst = 0;

        // R11 default length 8 without a start, R1 exact packing lanes
        cur_tag = "R11";
        push_tx(2); push_rx(4, 1);
        wait_idle();

        cur_tag = "R1";
        do_start(4);
        push_tx(2); push_rx(8, 0);
        wait_idle();
        cur_tag = "R4";
        push_rx(3, 1);
        wait_idle();

        cur_tag = "R1";
        do_start(32);
        push_tx(3); push_rx(2, 1);
        wait_idle();

        cur_tag = "R5";
        do_start(16);
        push_tx(2); push_rx(1, 1);
        wait_idle();
        do_start(8);
        push_rx(3, 1);
        wait_idle();
        push_rx(6, 1);
        wait_idle();

        cur_tag = "R2";
        do_start(12);
        push_tx(3); push_rx(2, 1);
        wait_idle();

        cur_tag = "R6";
        do_start(20);
        push_tx(2); push_rx(2, 1);
        wait_idle();
        do_start(6);
        push_tx(2); push_rx(1, 1);
        wait_idle();
        do_start(24);
        push_rx(1, 1);
        wait_idle();

        cur_tag = "R3";
        do_start(8);
        ready_mode = 1;
        push_tx(4); push_rx(5, 1);
        wait_idle();
        ready_mode = 0;

        cur_tag = "R7";
        do_start(16);
        push_tx(3); push_rx(5, 1);
        @(negedge clk);
        cfg_word_len = SPK_LEN_W'(8);
        wait_idle();

        cur_tag = "R8";
        do_start(8);
        budget = 2;
        push_tx(1); push_rx(2, 0);
        repeat (10) @(negedge clk);
        chk(tx_word_valid, "R8", "stalled word pending", 32'(tx_word_valid), 32'h1);
        budget = -1;
        do_start(8);
        txq.push_back(32'h4433_2211); push_rx(4, 1);
        wait_idle();

        cur_tag = "R9";
        do_start(2);
        push_tx(1); push_rx(8, 1);
        wait_idle();
        do_start(40);
        push_tx(2); push_rx(1, 1);
        wait_idle();

        cur_tag = "R12";
        do_start(32);
        hs_first = -1; hs_last = -1; hs_n = 0;
        push_tx(6);
        wait_idle();
        chk(hs_n == 6 && (hs_last - hs_first + 1) == 6, "R12", "gap-free stream span",
            32'(hs_last - hs_first + 1), 32'd6);

        cur_tag = "R10";
        do_start(16);
        push_rx(7, 1);
        wait_idle();
        chk(rx_push_count == 4, "R10", "final count", 32'(rx_push_count), 32'd4);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule